// File: doc/BRIEF.md
# Four-Step Fetch-Execute Sequencer

This block is the control sequencer and register datapath of a small 8-bit machine with a 16-bit address space. Every instruction takes exactly four clock cycles. In the first cycle, the program counter drives the address bus, the memory read strobe is raised, and the instruction register captures the byte on the data bus. In the second cycle, the program counter drives the address bus again, and a separate incrementer writes the next address into a holding register. In the third cycle, the holding register drives the address bus, and the program counter reloads from it. The fourth cycle executes the instruction.

Every register transfer is one select (drive a bus) and one load (capture a bus). At most one source drives each bus in a cycle, and a bus that nobody drives reads as zero. An arithmetic/logic instruction presents registers B and C to an external ALU, together with its function code. The ALU's result and flags are then written into register A or register D. Every other opcode is a no-operation. The ALU itself and the memory sit outside the block.

Top module: `fetch_exec_seq`

## Requirements
- R1: A synchronous reset, active high, sets the program counter to zero, registers A, B, C, D and the flags to zero, and the step output to 0 (fetch). This holds whatever step reset arrives in.
- R2: Without reset, the step output advances 0, 1, 2, 3, 0, ... by one each clock, so every instruction takes exactly four cycles.
- R3: In step 0, mem_addr equals the program counter and mem_rd is 1. mem_rd is 0 in every other step.
- R4: In step 1, mem_addr still shows the unchanged program counter. In step 2, it shows the program counter plus one. The next step 0 then fetches from that incremented address.
- R5: An opcode whose upper four bits are 1000 is an ALU instruction. In step 3 it raises alu_en and drives alu_fn with bits 2:0. At the end of step 3, alu_res loads into register A when bit 3 is 0, or into register D when bit 3 is 1, and alu_flags loads into flags.
- R6: Any opcode whose upper nibble is not 1000 leaves A, D and flags unchanged, and alu_en stays 0.
- R7: In step 3 no source drives the address bus, so mem_addr is zero. alu_en and alu_fn are zero outside step 3.
- R8: The program counter wraps from its all-ones value to zero.
- R9: During an ALU execute step, alu_b and alu_c present registers B and C. No instruction in this scope loads B or C, so both read zero after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Address bus (zero when undriven) |
| mem_rd | output | 1 | Memory read strobe |
| mem_data | input | DATA_W | Read data from memory |
| alu_en | output | 1 | ALU result is being captured this cycle |
| alu_fn | output | 3 | ALU function code |
| alu_b | output | DATA_W | Register B, first ALU operand |
| alu_c | output | DATA_W | Register C, second ALU operand |
| alu_res | input | DATA_W | ALU result |
| alu_flags | input | 3 | ALU flags (carry, zero, sign) |
| reg_a | output | DATA_W | Register A |
| reg_d | output | DATA_W | Register D |
| flags | output | 3 | Captured flags |
| step | output | 2 | Current step, 0 to 3 |

## Verification
The embedded assertions check the invariants that hold on every cycle. These are the step order, the read strobe being limited to fetch, the address bus being idle during execute, at most one driver per bus, the PC changing only through the update step and rising by one there, and no-operations leaving the registers alone. The directed scenarios are what show the data itself: an ALU result reaching the chosen destination and not the other register, the flags following it, the PC wrap at the top of the address space, and a reset taking effect in the middle of an instruction.

// File: rtl/fes_pkg.sv
package fes_pkg;
   localparam int FN_W   = 3;
   localparam int FLAG_W = 3;
   localparam int NGR    = 4;
   localparam int GR_A   = 0;
   localparam int GR_B   = 1;
   localparam int GR_C   = 2;
   localparam int GR_D   = 3;
   localparam logic [3:0] ALU_PFX = 4'b1000;

   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_INCR  = 2'd1,
      ST_UPD   = 2'd2,
      ST_EXEC  = 2'd3
   } step_e;

   typedef struct packed {
      logic            addr_pc;
      logic            addr_inc;
      logic            data_mem;
      logic            data_alu;
      logic            ld_ir;
      logic            ld_inc;
      logic            ld_pc;
      logic [NGR-1:0]  ld_gr;
      logic            ld_flg;
      logic            mem_rd;
      logic            alu_en;
      logic [FN_W-1:0] fn;
   } ctl_t;
endpackage

// File: rtl/fes_reg.sv
module fes_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ld,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("fes_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ld) q <= d;
   end
endmodule

// File: rtl/fes_inc.sv
module fes_inc #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [W-1:0] a,
   output logic [W-1:0] y
);
   if (W < 2) begin : g_bad_w
      $error("fes_inc: W must be at least 2");
   end

   if (RIPPLE) begin : g_ripple
      logic [W-1:0] cy;
      assign cy[0] = 1'b1;
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign y[i] = a[i] ^ cy[i];
         if (i < W - 1) begin : g_cy
            assign cy[i+1] = a[i] & cy[i];
         end
      end
   end else begin : g_adder
      assign y = a + {{(W-1){1'b0}}, 1'b1};
   end
endmodule

// File: rtl/fes_ctrl.sv
module fes_ctrl
   import fes_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] ir,
   output step_e         st,
   output ctl_t          ctl
);
   if (DW != 8) begin : g_bad_dw
      $error("fes_ctrl: opcode decode assumes an 8-bit instruction");
   end

   logic is_alu;
   logic dest_d;
   assign is_alu = (ir[7:4] == ALU_PFX);
   assign dest_d = ir[3];

   always_ff @(posedge clk) begin
      if (rst) st <= ST_FETCH;
      else begin
         case (st)
            ST_FETCH: st <= ST_INCR;
            ST_INCR:  st <= ST_UPD;
            ST_UPD:   st <= ST_EXEC;
            default:  st <= ST_FETCH;
         endcase
      end
   end

   always_comb begin
      ctl = '0;
      case (st)
         ST_FETCH: begin
            ctl.addr_pc  = 1'b1;
            ctl.mem_rd   = 1'b1;
            ctl.data_mem = 1'b1;
            ctl.ld_ir    = 1'b1;
         end
         ST_INCR: begin
            ctl.addr_pc = 1'b1;
            ctl.ld_inc  = 1'b1;
         end
         ST_UPD: begin
            ctl.addr_inc = 1'b1;
            ctl.ld_pc    = 1'b1;
         end
         default: begin
            if (is_alu) begin
               ctl.alu_en   = 1'b1;
               ctl.data_alu = 1'b1;
               ctl.fn       = ir[2:0];
               ctl.ld_flg   = 1'b1;
               if (dest_d) ctl.ld_gr[GR_D] = 1'b1;
               else        ctl.ld_gr[GR_A] = 1'b1;
            end
         end
      endcase
   end

   p_step_order_r2: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (st == step_e'($past(st) + 2'd1)));
   p_rd_fetch_only_r3: assert property (@(posedge clk) disable iff (rst)
      ctl.mem_rd |-> (st == ST_FETCH));
   p_alu_exec_only_r7: assert property (@(posedge clk) disable iff (rst)
      ctl.alu_en |-> (st == ST_EXEC));
endmodule

// File: rtl/fes_datapath.sv
module fes_datapath
   import fes_pkg::*;
#(
   parameter int AW         = 16,
   parameter int DW         = 8,
   parameter bit INC_RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  ctl_t              ctl,
   input  logic [DW-1:0]     mem_data,
   input  logic [DW-1:0]     alu_res,
   input  logic [FLAG_W-1:0] alu_flags,
   output logic [AW-1:0]     addr_bus,
   output logic [DW-1:0]     ir,
   output logic [DW-1:0]     gr [NGR],
   output logic [FLAG_W-1:0] flg
);
   if (AW < DW) begin : g_bad_aw
      $error("fes_datapath: address bus narrower than data bus");
   end

   logic [AW-1:0] pc, inc_q, inc_y;
   logic [DW-1:0] data_bus;

   assign addr_bus = ({AW{ctl.addr_pc}}  & pc)
                   | ({AW{ctl.addr_inc}} & inc_q);
   assign data_bus = ({DW{ctl.data_mem}} & mem_data)
                   | ({DW{ctl.data_alu}} & alu_res);

   fes_inc #(.W(AW), .RIPPLE(INC_RIPPLE)) u_inc (.a(addr_bus), .y(inc_y));

   fes_reg #(.W(AW)) u_pc  (.clk(clk), .rst(rst), .ld(ctl.ld_pc),  .d(addr_bus), .q(pc));
   fes_reg #(.W(AW)) u_hold(.clk(clk), .rst(rst), .ld(ctl.ld_inc), .d(inc_y),    .q(inc_q));
   fes_reg #(.W(DW)) u_ir  (.clk(clk), .rst(rst), .ld(ctl.ld_ir),  .d(data_bus), .q(ir));
   fes_reg #(.W(FLAG_W)) u_flg(.clk(clk), .rst(rst), .ld(ctl.ld_flg), .d(alu_flags), .q(flg));

   for (genvar g = 0; g < NGR; g++) begin : g_gr
      fes_reg #(.W(DW)) u_r (.clk(clk), .rst(rst), .ld(ctl.ld_gr[g]),
                             .d(data_bus), .q(gr[g]));
   end

   p_one_addr_drv_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.addr_pc, ctl.addr_inc}));
   p_one_data_drv_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({ctl.data_mem, ctl.data_alu}));
   p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
      !ctl.ld_pc |=> $stable(pc));
   p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
      ctl.ld_inc |=> (inc_q == $past(pc) + {{(AW-1){1'b0}}, 1'b1}));
   p_dest_a_r5: assert property (@(posedge clk) disable iff (rst)
      ctl.ld_gr[GR_A] |=> (gr[GR_A] == $past(alu_res)));
   p_one_dest_r5: assert property (@(posedge clk) disable iff (rst)
      $onehot0(ctl.ld_gr));
endmodule

// File: rtl/fetch_exec_seq.sv
module fetch_exec_seq
   import fes_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter bit INC_RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_rd,
   input  logic [DATA_W-1:0] mem_data,
   output logic              alu_en,
   output logic [FN_W-1:0]   alu_fn,
   output logic [DATA_W-1:0] alu_b,
   output logic [DATA_W-1:0] alu_c,
   input  logic [DATA_W-1:0] alu_res,
   input  logic [FLAG_W-1:0] alu_flags,
   output logic [DATA_W-1:0] reg_a,
   output logic [DATA_W-1:0] reg_d,
   output logic [FLAG_W-1:0] flags,
   output logic [1:0]        step
);
   step_e         st;
   ctl_t          ctl;
   logic [DATA_W-1:0] ir;
   logic [DATA_W-1:0] gr [NGR];

   fes_ctrl #(.DW(DATA_W)) u_ctrl (
      .clk(clk), .rst(rst), .ir(ir), .st(st), .ctl(ctl)
   );

   fes_datapath #(.AW(ADDR_W), .DW(DATA_W), .INC_RIPPLE(INC_RIPPLE)) u_dp (
      .clk(clk), .rst(rst), .ctl(ctl), .mem_data(mem_data),
      .alu_res(alu_res), .alu_flags(alu_flags), .addr_bus(mem_addr),
      .ir(ir), .gr(gr), .flg(flags)
   );

   assign mem_rd = ctl.mem_rd;
   assign alu_en = ctl.alu_en;
   assign alu_fn = ctl.fn;
   assign alu_b  = gr[GR_B];
   assign alu_c  = gr[GR_C];
   assign reg_a  = gr[GR_A];
   assign reg_d  = gr[GR_D];
   assign step   = st;

   p_addr_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (step == 2'd3) |-> (mem_addr == '0));
   p_nop_keeps_r6: assert property (@(posedge clk) disable iff (rst)
      ((step == 2'd3) && !alu_en) |=> ($stable(reg_a) && $stable(reg_d) && $stable(flags)));
   p_fetch_next_r4: assert property (@(posedge clk) disable iff (rst)
      (step == 2'd1) |=> (mem_addr == $past(mem_addr) + {{(ADDR_W-1){1'b0}}, 1'b1}));
   p_bc_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (alu_b == '0) && (alu_c == '0));
endmodule

// File: tb/fetch_exec_seq_tb_top.sv
`timescale 1ns/1ps
module fetch_exec_seq_tb_top;
   localparam int AW = 12;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic          mem_rd;
   logic [DW-1:0] mem_data;
   logic          alu_en;
   logic [2:0]    alu_fn;
   logic [DW-1:0] alu_b, alu_c, alu_res, reg_a, reg_d;
   logic [2:0]    alu_flags, flags;
   logic [1:0]    step;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [AW-1:0] exp_pc;
   logic [DW-1:0] exp_a, exp_d;
   logic [2:0]    exp_f;

   always #2.5 clk = ~clk;

   function automatic logic [7:0] prog(input logic [AW-1:0] a);
      case (a)
         12'd0: prog = 8'h80;
         12'd1: prog = 8'h8D;
         12'd2: prog = 8'h27;
         12'd3: prog = 8'h90;
         12'd4: prog = 8'h8E;
         12'd5: prog = 8'h83;
         12'd6: prog = 8'h88;
         12'd7: prog = 8'hFF;
         12'd8: prog = 8'h87;
         default: prog = 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] alu_model(input logic [2:0] f);
      alu_model = 8'h5A ^ {f, 5'b10011};
   endfunction

   function automatic logic [2:0] flag_model(input logic [2:0] f);
      flag_model = f ^ 3'b101;
   endfunction

   assign mem_data  = mem_rd ? prog(mem_addr) : 8'h00;
   assign alu_res   = alu_model(alu_fn);
   assign alu_flags = flag_model(alu_fn);

   fetch_exec_seq #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
      .mem_data(mem_data), .alu_en(alu_en), .alu_fn(alu_fn),
      .alu_b(alu_b), .alu_c(alu_c), .alu_res(alu_res), .alu_flags(alu_flags),
      .reg_a(reg_a), .reg_d(reg_d), .flags(flags), .step(step)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
      end
   endtask

   // One instruction; entered and left at the negedge of step 0.
   task automatic do_instr();
      logic [7:0] op;
      bit is_alu;
      op = prog(exp_pc);
      is_alu = (op[7:4] == 4'b1000);
      chk(step == 2'd0, "R2 step0", step, 0);
      chk(mem_addr == exp_pc, "R3 fetch addr", mem_addr, exp_pc);
      chk(mem_rd == 1'b1, "R3 rd in fetch", mem_rd, 1);
      @(negedge clk);
      chk(step == 2'd1, "R2 step1", step, 1);
      chk(mem_addr == exp_pc, "R4 pc in step1", mem_addr, exp_pc);
      chk(mem_rd == 1'b0, "R3 rd step1", mem_rd, 0);
      @(negedge clk);
      chk(step == 2'd2, "R2 step2", step, 2);
      chk(mem_addr == exp_pc + 1'b1, "R4 incr in step2", mem_addr, exp_pc + 1'b1);
      @(negedge clk);
      chk(step == 2'd3, "R2 step3", step, 3);
      chk(mem_addr == '0, "R7 addr idle", mem_addr, 0);
      chk(mem_rd == 1'b0, "R3 rd exec", mem_rd, 0);
      chk(alu_en == is_alu, "R5/R6 alu_en", alu_en, is_alu);
      chk(alu_fn == (is_alu ? op[2:0] : 3'd0), "R5 alu_fn", alu_fn,
          is_alu ? op[2:0] : 3'd0);
      if (is_alu) begin
         chk(alu_b == '0 && alu_c == '0, "R9 operands", {alu_b, alu_c}, 0);
         exp_f = flag_model(op[2:0]);
         if (op[3]) exp_d = alu_model(op[2:0]);
         else       exp_a = alu_model(op[2:0]);
      end
      @(negedge clk);
      exp_pc = exp_pc + 1'b1;
      chk(reg_a == exp_a, "R5/R6 reg_a", reg_a, exp_a);
      chk(reg_d == exp_d, "R5/R6 reg_d", reg_d, exp_d);
      chk(flags == exp_f, "R5/R6 flags", flags, exp_f);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      exp_pc = '0; exp_a = '0; exp_d = '0; exp_f = '0;
      chk(step == 2'd0, "R1 step", step, 0);
      chk(mem_addr == '0, "R1 pc", mem_addr, 0);
      chk(reg_a == '0 && reg_d == '0, "R1 regs", {reg_a, reg_d}, 0);
      chk(flags == '0, "R1 flags", flags, 0);
      chk(alu_en == 1'b0, "R7 alu_en idle", alu_en, 0);
   endtask

   task automatic t_program();
      for (int i = 0; i < 9; i++) do_instr();
   endtask

   task automatic t_mid_reset();
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk(step == 2'd0, "R1 mid step", step, 0);
      chk(mem_addr == '0, "R1 mid pc", mem_addr, 0);
      chk(reg_a == '0 && reg_d == '0 && flags == '0, "R1 mid regs",
          {reg_a, reg_d, 5'b0, flags}, 0);
      rst = 1'b0;
      exp_pc = '0; exp_a = '0; exp_d = '0; exp_f = '0;
   endtask

   task automatic t_wrap();
      bit seen = 1'b0;
      for (int i = 0; i < (1 << AW) + 2; i++) begin
         if (exp_pc == {AW{1'b1}}) begin
            do_instr();
            seen = 1'b1;
            chk(mem_addr == '0, "R8 wrap", mem_addr, 0);
         end else begin
            do_instr();
         end
      end
      chk(seen, "R8 wrap reached", seen, 1);
   endtask

   initial begin
      t_reset();
      t_program();
      t_mid_reset();
      t_program();
      t_wrap();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule